// File: doc/BRIEF.md
# Self-Timed Flash Operation Controller

This block sits behind a serial command front-end and carries out the long, self-timed operations of a small page-organised flash array. The array has two page-sized buffers. The front-end decodes a command. When chip select rises at the end of that command, the front-end presents the opcode and page address to this block for one cycle. The block then runs the matching sequence of internal phases: erase, program, transfer or compare. It holds its busy output high until the last phase has finished its byte loop and its hold time.

The block also produces the status byte. That byte carries the ready bit, the result of the most recent compare and a fixed density code. Buffer reads and writes from the front-end go straight to the buffers on a separate port, and they work while the array is busy.

Write protection covers the lowest pages and is controlled by an input pin. If an array command arrives while an operation is running, it is dropped and a sticky error flag is set. An asynchronous reset aborts any operation in progress. Phase hold times, page size and page count are parameters.

Top module: `flash_op_ctrl`

## Requirements
- R1: `status` is {ready, cmp_diff, 1, 1, 1, 1, 0, 0}, MSB first. Bit 7 is 1 when idle and 0 while busy, and reads 0xBC after reset.
- R2: A command is accepted on the clock edge where `cmd_valid` is high and `busy` is low. `busy` rises at that edge. A page erase (opcode 0x81) keeps `busy` high for exactly PAGE_BYTES+T_ERASE cycles.
- R3: Page erase (0x81) sets every byte of the addressed page to 0xFF and leaves other pages unchanged.
- R4: Block erase (0x50) erases the eight pages whose page-address bits above bit 2 match `cmd_page`. The low three page bits are ignored.
- R5: Program with erase copies a buffer into the page. Opcode 0x83 uses buffer 0 and 0x86 uses buffer 1.
- R6: Program without erase ANDs the buffer into the page, so bits only move from 1 to 0. Opcode 0x88 uses buffer 0 and 0x89 uses buffer 1.
- R7: Page to buffer transfer copies the page into a buffer. Opcode 0x53 targets buffer 0 and 0x55 targets buffer 1.
- R8: Compare (0x60 for buffer 0, 0x61 for buffer 1) sets status bit 6 to 0 if the page equals the buffer and to 1 if any bit differs. The bit changes only at the edge where the compare finishes.
- R9: Auto rewrite (0x58 for buffer 0, 0x59 for buffer 1) first transfers the page into the buffer, then erases the page, then programs the buffer back. The page keeps its data and the buffer ends up holding it.
- R10: When `cmd_valid` is high while `busy` is high, the command is dropped and `err` is set. `err` stays set until reset.
- R11: Buffer writes (`buf_we`) and buffer reads (`buf_rdata`, combinational on `buf_sel`/`buf_addr`) work while `busy` is high.
- R12: While `wp_n` is low, erase and program commands whose target page (the block base page for 0x50) is below PROT_PAGES are dropped: `busy` stays low and the array is unchanged. Transfer and compare are still accepted.
- R13: A low `rst_n` immediately returns the controller to idle (`busy` low) and clears `err` and the compare bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset and abort |
| cmd_valid | input | 1 | One-cycle strobe carrying a decoded array command |
| cmd_op | input | 8 | Command opcode |
| cmd_page | input | PAW | Page address of the command |
| wp_n | input | 1 | Low protects the lowest PROT_PAGES pages |
| buf_we | input | 1 | Buffer write strobe |
| buf_sel | input | 1 | Buffer select for host access |
| buf_addr | input | BW | Byte address in the buffer |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data |
| busy | output | 1 | High while an array operation runs |
| err | output | 1 | Sticky flag for a command dropped while busy |
| status | output | 8 | Status byte |

## Verification
On every cycle the assertions check four things:
- `busy` rises only on a command strobe.
- A strobe while busy always leaves `err` set.
- A protected page erase never starts.
- The compare bit moves only when `busy` falls.

The data effects can only be shown by the bench scenarios, which read pages back through a transfer into a buffer. These effects are:
- erase to 0xFF, block alignment, program with and without erase, and rewrite keeping the data;
- the exact busy length;
- the contents of a dropped or protected target staying the same;
- a mid-operation abort.

// File: rtl/flash_op_ctrl.sv
module flash_op_ctrl #(
  parameter int PAGES      = 32,
  parameter int PAGE_BYTES = 8,
  parameter int PROT_PAGES = 8,
  parameter int T_ERASE    = 20,
  parameter int T_PROG     = 12,
  parameter int T_XFER     = 4,
  localparam int PAW = $clog2(PAGES),
  localparam int BW  = $clog2(PAGE_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_op,
  input  logic [PAW-1:0] cmd_page,
  input  logic           wp_n,
  input  logic           buf_we,
  input  logic           buf_sel,
  input  logic [BW-1:0]  buf_addr,
  input  logic [7:0]     buf_wdata,
  output logic [7:0]     buf_rdata,
  output logic           busy,
  output logic           err,
  output logic [7:0]     status
);
  localparam int MAW = PAW + BW;
  localparam int CW  = 16;
  localparam logic [CW-1:0] L_PAGE = CW'(PAGE_BYTES);
  localparam logic [CW-1:0] L_BLK  = CW'(8 * PAGE_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_XFER, S_ERASE, S_PROG, S_CMP} st_t;

  st_t            state;
  logic [CW-1:0]  cnt;
  logic [PAW-1:0] pg_r;
  logic           bsel_r, blk_r, cmpf, mism;
  logic           f_x, f_e, f_p, f_c;

  logic [7:0] mem  [PAGES*PAGE_BYTES];
  logic [7:0] bufm [2*PAGE_BYTES];

  logic d_ok, d_x, d_e, d_p, d_c, d_blk, d_b;
  always_comb begin
    {d_ok, d_x, d_e, d_p, d_c, d_blk, d_b} = '0;
    case (cmd_op)
      8'h81: {d_ok, d_e} = 2'b11;
      8'h50: {d_ok, d_e, d_blk} = 3'b111;
      8'h83, 8'h86: {d_ok, d_e, d_p} = 3'b111;
      8'h88, 8'h89: {d_ok, d_p} = 2'b11;
      8'h53, 8'h55: {d_ok, d_x} = 2'b11;
      8'h60, 8'h61: {d_ok, d_c} = 2'b11;
      8'h58, 8'h59: {d_ok, d_x, d_e, d_p} = 4'b1111;
      default: ;
    endcase
    d_b = (cmd_op == 8'h86) || (cmd_op == 8'h89) || (cmd_op == 8'h55) ||
          (cmd_op == 8'h61) || (cmd_op == 8'h59);
  end

  function automatic st_t pick(input logic x, e, p, c);
    if (x)      return S_XFER;
    else if (e) return S_ERASE;
    else if (p) return S_PROG;
    else if (c) return S_CMP;
    else        return S_IDLE;
  endfunction

  wire [PAW-1:0] tgt_page = d_blk ? {cmd_page[PAW-1:3], 3'b000} : cmd_page;
  wire           wr_op    = d_e | d_p;
  wire           blocked  = wr_op && !wp_n && (int'(tgt_page) < PROT_PAGES);
  wire           accept   = cmd_valid && d_ok && !busy && !blocked;

  logic [CW-1:0] len, hold;
  always_comb begin
    len  = (state == S_ERASE && blk_r) ? L_BLK : L_PAGE;
    case (state)
      S_ERASE: hold = CW'(T_ERASE);
      S_PROG:  hold = CW'(T_PROG);
      default: hold = CW'(T_XFER);
    endcase
  end

  wire           last     = (cnt == len + hold - 1'b1);
  wire           in_bytes = (cnt < len);
  wire [MAW-1:0] midx     = {pg_r, {BW{1'b0}}} + cnt[MAW-1:0];
  wire [BW:0]    bidx     = {bsel_r, cnt[BW-1:0]};
  wire           nx_x     = f_x && (state != S_XFER);
  wire           nx_e     = f_e && (state != S_ERASE);
  wire           nx_p     = f_p && (state != S_PROG);
  wire           nx_c     = f_c && (state != S_CMP);

  assign busy      = (state != S_IDLE);
  assign status    = {~busy, cmpf, 4'hF, 2'b00};
  assign buf_rdata = bufm[{buf_sel, buf_addr}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      pg_r  <= '0;
      {bsel_r, blk_r, cmpf, mism, err} <= '0;
      {f_x, f_e, f_p, f_c} <= '0;
    end else begin
      if (cmd_valid && busy) err <= 1'b1;
      if (accept) begin
        state  <= pick(d_x, d_e, d_p, d_c);
        {f_x, f_e, f_p, f_c} <= {d_x, d_e, d_p, d_c};
        pg_r   <= tgt_page;
        bsel_r <= d_b;
        blk_r  <= d_blk;
        mism   <= 1'b0;
        cnt    <= '0;
      end else if (busy) begin
        if (state == S_CMP && in_bytes && (mem[midx] != bufm[bidx])) mism <= 1'b1;
        if (last) begin
          {f_x, f_e, f_p, f_c} <= {nx_x, nx_e, nx_p, nx_c};
          state <= pick(nx_x, nx_e, nx_p, nx_c);
          cnt   <= '0;
          if (state == S_CMP) cmpf <= mism;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_bytes) begin
      if (state == S_ERASE) mem[midx] <= 8'hFF;
      if (state == S_PROG)  mem[midx] <= mem[midx] & bufm[bidx];
      if (state == S_XFER)  bufm[bidx] <= mem[midx];
    end
    if (buf_we) bufm[{buf_sel, buf_addr}] <= buf_wdata;
  end

  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  // R10
  drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |=> err);
  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(cmd_valid && busy));
  // R12
  prot_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && !wp_n && cmd_op == 8'h81 && int'(cmd_page) < PROT_PAGES |=> !busy);
  // R8
  cmp_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status[6]) |-> $fell(busy));
endmodule

// File: tb/flash_op_ctrl_tb_top.sv
module flash_op_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PB = 8;
  localparam int T_ERASE = 20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0, wp_n = 1'b1, buf_we = 1'b0, buf_sel = 1'b0;
  logic [7:0] cmd_op = 8'h00, buf_wdata = 8'h00;
  logic [4:0] cmd_page = '0;
  logic [2:0] buf_addr = '0;
  logic [7:0] buf_rdata, status;
  logic       busy, err;

  int total = 0, bad = 0;
  logic [7:0] got [PB];
  logic [7:0] exp_v [PB];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_op_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .wp_n(wp_n), .buf_we(buf_we), .buf_sel(buf_sel),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .busy(busy), .err(err), .status(status));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [4:0] pg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = pg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic bwrite(input logic s, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    buf_we = 1'b1; buf_sel = s; buf_addr = a; buf_wdata = d;
    @(negedge clk);
    buf_we = 1'b0;
  endtask

  task automatic bread(input logic s, input logic [2:0] a, output logic [7:0] d);
    buf_sel = s; buf_addr = a;
    #1 d = buf_rdata;
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29) + (i * 13) + 3);
  endfunction

  task automatic fill(input logic s, input int seed);
    for (int i = 0; i < PB; i++) bwrite(s, 3'(i), pat(seed, i));
  endtask

  task automatic program_page(input logic [4:0] pg, input int seed);
    fill(1'b0, seed);
    send(8'h83, pg);
    wait_idle();
  endtask

  task automatic read_page(input logic [4:0] pg);
    send(8'h55, pg);
    wait_idle();
    for (int i = 0; i < PB; i++) bread(1'b1, 3'(i), got[i]);
  endtask

  function automatic bit same();
    for (int i = 0; i < PB; i++) if (got[i] !== exp_v[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic set_exp(input int seed);
    for (int i = 0; i < PB; i++) exp_v[i] = (seed < 0) ? 8'hFF : pat(seed, i);
  endtask

  task automatic t_reset();
    chk(status == 8'hBC, "R1 reset status", status, 8'hBC);
    chk(!busy && !err, "R13 reset idle", {busy, err}, 0);
  endtask

  task automatic t_erase_prog();
    int n;
    program_page(5'd10, 1);
    read_page(5'd10); set_exp(1);
    chk(same(), "R5 program with erase", got[0], exp_v[0]);
    chk(same(), "R7 transfer to buffer", got[7], exp_v[7]);
    program_page(5'd9, 2);
    send(8'h81, 5'd9);
    chk(status[7] == 1'b0, "R1 busy bit", status, 8'h3C);
    n = 1;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
    chk(n == PB + T_ERASE, "R2 busy length", n, PB + T_ERASE);
    read_page(5'd9); set_exp(-1);
    chk(same(), "R3 page erased", got[0], 8'hFF);
    read_page(5'd10); set_exp(1);
    chk(same(), "R3 neighbour kept", got[0], exp_v[0]);
  endtask

  task automatic t_prog_noerase();
    fill(1'b0, 4);
    send(8'h88, 5'd10); wait_idle();
    read_page(5'd10);
    for (int i = 0; i < PB; i++) exp_v[i] = pat(1, i) & pat(4, i);
    chk(same(), "R6 program AND", got[2], exp_v[2]);
    for (int i = 0; i < PB; i++) bwrite(1'b1, 3'(i), 8'hFF);
    send(8'h89, 5'd10); wait_idle();
    read_page(5'd10);
    chk(same(), "R6 AND with ones keeps page", got[2], exp_v[2]);
  endtask

  task automatic t_compare();
    send(8'h61, 5'd10);
    wait_idle();
    chk(status == 8'hBC, "R8 compare match", status, 8'hBC);
    bwrite(1'b1, 3'd3, ~exp_v[3]);
    send(8'h61, 5'd10);
    chk(status[6] == 1'b0, "R8 bit held during compare", status, 8'h3C);
    wait_idle();
    chk(status == 8'hFC, "R8 compare mismatch", status, 8'hFC);
  endtask

  task automatic t_block();
    program_page(5'd16, 5);
    program_page(5'd23, 6);
    program_page(5'd24, 7);
    send(8'h50, 5'd19); wait_idle();
    read_page(5'd16); set_exp(-1);
    chk(same(), "R4 block first page", got[0], 8'hFF);
    read_page(5'd23);
    chk(same(), "R4 block last page", got[0], 8'hFF);
    read_page(5'd24); set_exp(7);
    chk(same(), "R4 next block kept", got[0], exp_v[0]);
  endtask

  task automatic t_rewrite();
    logic [7:0] d;
    bit ok = 1'b1;
    for (int i = 0; i < PB; i++) bwrite(1'b0, 3'(i), 8'h00);
    send(8'h58, 5'd24); wait_idle();
    set_exp(7);
    for (int i = 0; i < PB; i++) begin bread(1'b0, 3'(i), d); if (d !== exp_v[i]) ok = 1'b0; end
    chk(ok, "R9 rewrite buffer loaded", d, exp_v[PB-1]);
    read_page(5'd24);
    chk(same(), "R9 rewrite page kept", got[0], exp_v[0]);
  endtask

  task automatic t_drop();
    program_page(5'd13, 8);
    send(8'h81, 5'd12);
    send(8'h81, 5'd13);
    chk(err == 1'b1, "R10 err set", err, 1);
    wait_idle();
    read_page(5'd13); set_exp(8);
    chk(same(), "R10 dropped command no effect", got[0], exp_v[0]);
    chk(err == 1'b1, "R10 err sticky", err, 1);
  endtask

  task automatic t_buf_busy();
    logic [7:0] d;
    send(8'h81, 5'd12);
    bwrite(1'b1, 3'd2, 8'h5A);
    bread(1'b1, 3'd2, d);
    chk(d == 8'h5A && busy, "R11 buffer access while busy", {busy, d}, 9'h15A);
    wait_idle();
  endtask

  task automatic t_protect();
    program_page(5'd3, 9);
    wp_n = 1'b0;
    send(8'h81, 5'd3);
    chk(!busy, "R12 protected erase dropped", busy, 0);
    send(8'h50, 5'd5);
    chk(!busy, "R12 protected block erase dropped", busy, 0);
    read_page(5'd3); set_exp(9);
    chk(same(), "R12 protected page kept", got[0], exp_v[0]);
    send(8'h81, 5'd9);
    chk(busy, "R12 unprotected erase accepted", busy, 1);
    wait_idle();
    wp_n = 1'b1;
  endtask

  task automatic t_abort();
    chk(status[6] && err, "R13 flags set before abort", {status[6], err}, 3);
    send(8'h83, 5'd10);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1 chk(!busy, "R13 abort immediate", busy, 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 8'hBC && !err, "R13 abort clears", {err, status}, 8'hBC);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_erase_prog();
    t_prog_noerase();
    t_compare();
    t_block();
    t_rewrite();
    t_drop();
    t_buf_busy();
    t_protect();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule